// File: doc/BRIEF.md
# Mode-Banked General Register File

This block stores the general-purpose registers and status words of a 32-bit processor core that runs in one of seven operating modes. An architectural register index of 4 bits names a register, and the current mode picks which physical copy that index reaches. Indices 0 to 7 always reach the same storage. Indices 8 to 12 have a separate copy for fast-interrupt mode. The stack pointer (index 13) and the link register (index 14) have a private copy for each exception mode. The fetch logic holds the program counter (index 15), so this block does not store it.

The block has two combinational read ports and one write port. The write port commits on the rising clock edge. Reads decode with `cur_mode`. Writes decode with a separate `wr_mode`, so exception-entry logic can load the link register and saved status of the mode being entered while the current mode is still the old one. The block also holds the current status word and one saved status word for each of the five exception modes. A design-wide reset synchroniser must release `rst_n` in step with `clk`.

Top module: `mbrf_regfile`

## Requirements
- R1: While `rst_n` is low and after it is released, every general register reads 0. The current status word reads 32'h0000_0013 (the supervisor mode code in bits 4:0). Every saved status word reads 0.
- R2: Indices 0 to 7 reach one shared set of registers. A value written in any mode reads back the same in every mode.
- R3: Indices 8 to 12 reach one copy in fast-interrupt mode (5'b10001). In every other mode they reach a second, shared copy. A write to one copy leaves the other copy unchanged.
- R4: Indices 13 and 14 reach a private copy in each of fast-interrupt, interrupt (5'b10010), supervisor (5'b10011), abort (5'b10111) and undefined (5'b11011) modes. User (5'b10000) and system (5'b11111) modes share one copy.
- R5: Index 15 reads as 0 on both read ports. A write to index 15 changes no register.
- R6: Ports A and B each return the register named by their own index in `cur_mode`, combinationally and at the same time.
- R7: A register write takes effect at the clock edge where `wr_en` is high. A read of that register in the same cycle returns the old value. A register that is not written holds its value.
- R8: A register write selects its physical copy with `wr_mode`, independently of `cur_mode`.
- R9: A saved-status write while `wr_mode` names an exception mode updates that mode's saved word. `sst_rdata` shows the saved word of the mode in `cur_mode`.
- R10: When the mode is user or system, `sst_rdata` reads 0 and a saved-status write changes no saved word.
- R11: A current-status write loads `cst_wdata` at the clock edge, and `cst_rdata` shows it from the next cycle on.
- R12: A mode code outside the seven defined codes uses the user/system copies of the registers and has no saved status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cur_mode | input | 5 | Mode used to decode both read ports and the saved-status read |
| wr_mode | input | 5 | Mode used to decode register writes and saved-status writes |
| rd_a_idx | input | 4 | Architectural index for read port A |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Architectural index for read port B |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Architectural index for the write |
| wr_data | input | 32 | Register write data |
| cst_we | input | 1 | Current status word write enable |
| cst_wdata | input | 32 | Current status word write data |
| cst_rdata | output | 32 | Current status word |
| sst_we | input | 1 | Saved status word write enable |
| sst_wdata | input | 32 | Saved status word write data |
| sst_rdata | output | 32 | Saved status word of `cur_mode` |

## Verification
The bench writes a different value to index 13 in every mode and reads each one back. A design with a wrong bank mapping would return another mode's stack pointer, or would let a fast-interrupt write to index 10 overwrite the copy the other modes see. It writes with `wr_mode` different from `cur_mode`. A design that decoded writes with `cur_mode` would corrupt the link register of the interrupted mode. It checks a read of a register during the cycle that register is being written. A forwarding path there would return the new value too early. It also writes to index 15 and to the saved status word in user mode, then checks that the neighbouring registers and the other saved words still hold their values. An incomplete write guard would show up there as a silently changed register.

// File: rtl/mbrf_pkg.sv
package mbrf_pkg;

  localparam int unsigned IDX_W      = 4;
  localparam int unsigned MODE_W     = 5;
  localparam int unsigned NUM_SHARED = 8;   // indices 0..7
  localparam int unsigned NUM_HI     = 5;   // indices 8..12
  localparam int unsigned NUM_BANKS  = 6;   // user/system plus five exception modes
  localparam int unsigned NUM_PHYS   = NUM_SHARED + 2 * NUM_HI + 2 * NUM_BANKS;
  localparam int unsigned SLOT_W     = $clog2(NUM_PHYS);
  localparam int unsigned FIQ_HI_BASE = NUM_SHARED + NUM_HI;
  localparam int unsigned SPLR_BASE   = NUM_SHARED + 2 * NUM_HI;
  localparam int unsigned IDX_SP      = 13;
  localparam int unsigned IDX_LR      = 14;

  typedef enum logic [MODE_W-1:0] {
    MD_USR = 5'b10000,
    MD_FIQ = 5'b10001,
    MD_IRQ = 5'b10010,
    MD_SVC = 5'b10011,
    MD_ABT = 5'b10111,
    MD_UND = 5'b11011,
    MD_SYS = 5'b11111
  } cpu_mode_e;

  typedef enum logic [2:0] {
    BK_USR = 3'd0,
    BK_FIQ = 3'd1,
    BK_IRQ = 3'd2,
    BK_SVC = 3'd3,
    BK_ABT = 3'd4,
    BK_UND = 3'd5
  } bank_e;

  // User, system and undefined codes all fall back to the shared bank.
  function automatic bank_e mode_bank(input logic [MODE_W-1:0] m);
    case (m)
      MD_FIQ:  return BK_FIQ;
      MD_IRQ:  return BK_IRQ;
      MD_SVC:  return BK_SVC;
      MD_ABT:  return BK_ABT;
      MD_UND:  return BK_UND;
      default: return BK_USR;
    endcase
  endfunction

endpackage

// File: rtl/mbrf_map.sv
module mbrf_map
  import mbrf_pkg::*;
(
  input  logic [IDX_W-1:0]  idx,
  input  logic [MODE_W-1:0] mode,
  output logic              hit,
  output logic [SLOT_W-1:0] slot
);

  bank_e bank;
  int    idx_i;

  always_comb begin
    bank  = mode_bank(mode);
    idx_i = int'(idx);
    hit   = 1'b1;
    slot  = '0;
    if (idx_i < NUM_SHARED) begin
      slot = SLOT_W'(idx_i);
    end else if (idx_i < NUM_SHARED + NUM_HI) begin
      slot = (bank == BK_FIQ) ? SLOT_W'(idx_i - NUM_SHARED + FIQ_HI_BASE)
                              : SLOT_W'(idx_i);
    end else if (idx_i <= IDX_LR) begin
      slot = SLOT_W'(SPLR_BASE + 2 * int'(bank) + (idx_i - IDX_SP));
    end else begin
      hit  = 1'b0;
    end
  end

endmodule

// File: rtl/mbrf_status.sv
module mbrf_status
  import mbrf_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] cur_mode,
  input  logic [MODE_W-1:0] wr_mode,
  input  logic              cst_we,
  input  logic [DATA_W-1:0] cst_wdata,
  output logic [DATA_W-1:0] cst_rdata,
  input  logic              sst_we,
  input  logic [DATA_W-1:0] sst_wdata,
  output logic [DATA_W-1:0] sst_rdata
);

  localparam int unsigned NUM_SAVED = NUM_BANKS - 1;
  localparam logic [DATA_W-1:0] CST_RST = DATA_W'(MD_SVC);

  logic [DATA_W-1:0] cst_q, cst_d;
  logic [DATA_W-1:0] sav_q [NUM_SAVED];
  logic [DATA_W-1:0] sav_d [NUM_SAVED];
  bank_e             rd_bank, wr_bank;

  always_comb begin
    rd_bank = mode_bank(cur_mode);
    wr_bank = mode_bank(wr_mode);
    cst_d   = cst_we ? cst_wdata : cst_q;
    for (int k = 0; k < NUM_SAVED; k++) begin
      sav_d[k] = (sst_we && (int'(wr_bank) == k + 1)) ? sst_wdata : sav_q[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cst_q <= CST_RST;
      for (int k = 0; k < NUM_SAVED; k++) sav_q[k] <= '0;
    end else begin
      cst_q <= cst_d;
      for (int k = 0; k < NUM_SAVED; k++) sav_q[k] <= sav_d[k];
    end
  end

  always_comb begin
    cst_rdata = cst_q;
    sst_rdata = '0;
    for (int k = 0; k < NUM_SAVED; k++) begin
      if (int'(rd_bank) == k + 1) sst_rdata = sav_q[k];
    end
  end

  for (genvar g = 0; g < NUM_SAVED; g++) begin : g_sav_chk
    // R10
    sst_usr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sst_we && wr_bank == BK_USR) |=> $stable(sav_q[g]));
    // R9
    sst_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sst_we && int'(wr_bank) == g + 1) |=> (sav_q[g] == $past(sst_wdata)));
  end

  // R11
  cst_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cst_we |=> (cst_rdata == $past(cst_wdata)));

endmodule

// File: rtl/mbrf_regfile.sv
module mbrf_regfile
  import mbrf_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        cur_mode,
  input  logic [4:0]        wr_mode,
  input  logic [3:0]        rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [3:0]        rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [3:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cst_we,
  input  logic [DATA_W-1:0] cst_wdata,
  output logic [DATA_W-1:0] cst_rdata,
  input  logic              sst_we,
  input  logic [DATA_W-1:0] sst_wdata,
  output logic [DATA_W-1:0] sst_rdata
);

  logic [DATA_W-1:0]   regs_q [NUM_PHYS];
  logic [DATA_W-1:0]   regs_d [NUM_PHYS];
  logic [NUM_PHYS-1:0] slot_we;

  logic              a_hit, b_hit, w_hit;
  logic [SLOT_W-1:0] a_slot, b_slot, w_slot;

  mbrf_map u_map_a (.idx(rd_a_idx), .mode(cur_mode), .hit(a_hit), .slot(a_slot));
  mbrf_map u_map_b (.idx(rd_b_idx), .mode(cur_mode), .hit(b_hit), .slot(b_slot));
  mbrf_map u_map_w (.idx(wr_idx),   .mode(wr_mode),  .hit(w_hit), .slot(w_slot));

  // Write decode and next state
  always_comb begin
    slot_we = '0;
    if (wr_en && w_hit) slot_we[w_slot] = 1'b1;
    for (int i = 0; i < NUM_PHYS; i++) begin
      regs_d[i] = slot_we[i] ? wr_data : regs_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_PHYS; i++) regs_q[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_PHYS; i++) regs_q[i] <= regs_d[i];
    end
  end

  // Read ports
  always_comb begin
    rd_a_data = a_hit ? regs_q[a_slot] : '0;
    rd_b_data = b_hit ? regs_q[b_slot] : '0;
  end

  mbrf_status #(.DATA_W(DATA_W)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .cur_mode (cur_mode),
    .wr_mode  (wr_mode),
    .cst_we   (cst_we),
    .cst_wdata(cst_wdata),
    .cst_rdata(cst_rdata),
    .sst_we   (sst_we),
    .sst_wdata(sst_wdata),
    .sst_rdata(sst_rdata)
  );

  // R3 R4
  wr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_we));

  // R5
  pc_wr_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_idx == 4'd15) |-> (slot_we == '0));

  // R5
  pc_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_a_idx == 4'd15) |-> (rd_a_data == '0)) and
    ((rd_b_idx == 4'd15) |-> (rd_b_data == '0)));

  for (genvar g = 0; g < NUM_PHYS; g++) begin : g_hold_chk
    // R7
    slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_we[g] |=> $stable(regs_q[g]));
  end

endmodule

// File: tb/sim_mbrf_regfile.sv
module sim_mbrf_regfile;

  localparam time CLK_PERIOD = 10ns;

  localparam logic [4:0] USR = 5'b10000, FIQ = 5'b10001, IRQ = 5'b10010,
                         SVC = 5'b10011, ABT = 5'b10111, UND = 5'b11011,
                         SYS = 5'b11111, BAD = 5'b00000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  cur_mode, wr_mode;
  logic [3:0]  rd_a_idx, rd_b_idx, wr_idx;
  logic [31:0] rd_a_data, rd_b_data, wr_data;
  logic        wr_en, cst_we, sst_we;
  logic [31:0] cst_wdata, cst_rdata, sst_wdata, sst_rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mbrf_regfile u0 (
    .clk(clk), .rst_n(rst_n), .cur_mode(cur_mode), .wr_mode(wr_mode),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .cst_we(cst_we), .cst_wdata(cst_wdata), .cst_rdata(cst_rdata),
    .sst_we(sst_we), .sst_wdata(sst_wdata), .sst_rdata(sst_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [4:0] m, input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk);
    wr_mode = m; wr_idx = idx; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_sst(input logic [4:0] m, input logic [31:0] d);
    @(negedge clk);
    wr_mode = m; sst_wdata = d; sst_we = 1'b1;
    @(negedge clk);
    sst_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [4:0] m, input logic [3:0] idx, output logic [31:0] v);
    cur_mode = m; rd_a_idx = idx;
    #1;
    v = rd_a_data;
  endtask

  task automatic rd_sst(input logic [4:0] m, output logic [31:0] v);
    cur_mode = m;
    #1;
    v = sst_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int i = 0; i < 15; i++) begin
      rd_reg(SVC, 4'(i), v); chk("R1 svc reg zero", v, 32'h0);
      rd_reg(FIQ, 4'(i), v); chk("R1 fiq reg zero", v, 32'h0);
    end
    rd_reg(UND, 4'd13, v); chk("R1 und sp zero", v, 32'h0);
    chk("R1 cst reset", cst_rdata, 32'h0000_0013);
    rd_sst(SVC, v); chk("R1 sst svc zero", v, 32'h0);
    rd_sst(FIQ, v); chk("R1 sst fiq zero", v, 32'h0);
  endtask

  task automatic t_shared;
    logic [31:0] v;
    wr_reg(USR, 4'd5, 32'hA5A5_0005);
    rd_reg(FIQ, 4'd5, v); chk("R2 r5 in fiq", v, 32'hA5A5_0005);
    rd_reg(UND, 4'd5, v); chk("R2 r5 in und", v, 32'hA5A5_0005);
    wr_reg(FIQ, 4'd7, 32'h7777_0007);
    rd_reg(SYS, 4'd7, v); chk("R2 r7 in sys", v, 32'h7777_0007);
  endtask

  task automatic t_fiq_hi;
    logic [31:0] v;
    wr_reg(USR, 4'd10, 32'hB0B0_000A);
    wr_reg(FIQ, 4'd10, 32'hC0C0_000A);
    rd_reg(USR, 4'd10, v); chk("R3 r10 usr", v, 32'hB0B0_000A);
    rd_reg(IRQ, 4'd10, v); chk("R3 r10 irq", v, 32'hB0B0_000A);
    rd_reg(SYS, 4'd10, v); chk("R3 r10 sys", v, 32'hB0B0_000A);
    rd_reg(FIQ, 4'd10, v); chk("R3 r10 fiq", v, 32'hC0C0_000A);
    rd_reg(FIQ, 4'd12, v); chk("R3 r12 fiq untouched", v, 32'h0);
  endtask

  task automatic t_banked;
    logic [4:0]  modes [6] = '{USR, FIQ, IRQ, SVC, ABT, UND};
    logic [31:0] v;
    for (int k = 0; k < 6; k++) wr_reg(modes[k], 4'd13, 32'h1300_0000 + 32'(k));
    for (int k = 0; k < 6; k++) begin
      rd_reg(modes[k], 4'd13, v); chk("R4 sp per mode", v, 32'h1300_0000 + 32'(k));
    end
    rd_reg(SYS, 4'd13, v); chk("R4 sys sp shares usr", v, 32'h1300_0000);
    wr_reg(SYS, 4'd14, 32'h1414_0000);
    rd_reg(USR, 4'd14, v); chk("R4 usr lr shares sys", v, 32'h1414_0000);
    rd_reg(SVC, 4'd14, v); chk("R4 svc lr separate", v, 32'h0);
  endtask

  task automatic t_pc;
    logic [31:0] v;
    wr_reg(SVC, 4'd15, 32'hFFFF_FFFF);
    rd_reg(SVC, 4'd15, v); chk("R5 r15 reads zero", v, 32'h0);
    rd_reg(SVC, 4'd13, v); chk("R5 svc sp kept", v, 32'h1300_0003);
    rd_reg(SVC, 4'd14, v); chk("R5 svc lr kept", v, 32'h0);
    rd_reg(SVC, 4'd5, v);  chk("R5 r5 kept", v, 32'hA5A5_0005);
    rd_reg(SVC, 4'd0, v);  chk("R5 r0 kept", v, 32'h0);
    rd_reg(SVC, 4'd12, v); chk("R5 r12 kept", v, 32'h0);
  endtask

  task automatic t_dual;
    cur_mode = FIQ; rd_a_idx = 4'd5; rd_b_idx = 4'd10;
    #1;
    chk("R6 port a r5", rd_a_data, 32'hA5A5_0005);
    chk("R6 port b r10 fiq", rd_b_data, 32'hC0C0_000A);
    rd_a_idx = 4'd13; rd_b_idx = 4'd15;
    #1;
    chk("R6 port a fiq sp", rd_a_data, 32'h1300_0001);
    chk("R6 port b r15", rd_b_data, 32'h0);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    cur_mode = IRQ; rd_a_idx = 4'd3; rd_b_idx = 4'd3;
    wr_mode = IRQ; wr_idx = 4'd3; wr_data = 32'h3333_0003; wr_en = 1'b1;
    #1;
    chk("R7 old value during write", rd_a_data, 32'h0);
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    chk("R7 new value after edge", rd_b_data, 32'h3333_0003);
  endtask

  task automatic t_wr_mode;
    logic [31:0] v;
    @(negedge clk);
    cur_mode = USR; wr_mode = IRQ; wr_idx = 4'd14; wr_data = 32'hD00D_0014; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    rd_reg(USR, 4'd14, v); chk("R8 usr lr untouched", v, 32'h1414_0000);
    rd_reg(IRQ, 4'd14, v); chk("R8 irq lr loaded", v, 32'hD00D_0014);
  endtask

  task automatic t_saved;
    logic [31:0] v;
    wr_sst(ABT, 32'hE000_0017);
    wr_sst(UND, 32'hF000_001B);
    rd_sst(ABT, v); chk("R9 sst abt", v, 32'hE000_0017);
    rd_sst(UND, v); chk("R9 sst und", v, 32'hF000_001B);
    rd_sst(SVC, v); chk("R9 sst svc untouched", v, 32'h0);
  endtask

  task automatic t_saved_usr;
    logic [31:0] v;
    wr_sst(USR, 32'h6666_6666);
    wr_sst(SYS, 32'h5555_5555);
    rd_sst(USR, v); chk("R10 sst usr zero", v, 32'h0);
    rd_sst(SYS, v); chk("R10 sst sys zero", v, 32'h0);
    rd_sst(ABT, v); chk("R10 sst abt kept", v, 32'hE000_0017);
    rd_sst(IRQ, v); chk("R10 sst irq kept", v, 32'h0);
    rd_sst(FIQ, v); chk("R10 sst fiq kept", v, 32'h0);
    rd_sst(SVC, v); chk("R10 sst svc kept", v, 32'h0);
  endtask

  task automatic t_cst;
    @(negedge clk);
    cst_wdata = 32'h8000_00D1; cst_we = 1'b1;
    #1;
    chk("R11 cst before edge", cst_rdata, 32'h0000_0013);
    @(negedge clk);
    cst_we = 1'b0;
    chk("R11 cst after edge", cst_rdata, 32'h8000_00D1);
  endtask

  task automatic t_unknown;
    logic [31:0] v;
    rd_reg(BAD, 4'd10, v); chk("R12 bad mode r10", v, 32'hB0B0_000A);
    rd_reg(BAD, 4'd13, v); chk("R12 bad mode sp", v, 32'h1300_0000);
    rd_sst(BAD, v); chk("R12 bad mode sst", v, 32'h0);
    wr_reg(BAD, 4'd14, 32'h0BAD_0014);
    rd_reg(SYS, 4'd14, v); chk("R12 bad write to sys lr", v, 32'h0BAD_0014);
  endtask

  initial begin
    rst_n = 1'b0;
    cur_mode = SVC; wr_mode = SVC;
    rd_a_idx = '0; rd_b_idx = '0; wr_idx = '0; wr_data = '0; wr_en = 1'b0;
    cst_we = 1'b0; cst_wdata = '0; sst_we = 1'b0; sst_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_shared();
    t_fiq_hi();
    t_banked();
    t_pc();
    t_dual();
    t_same_cycle();
    t_wr_mode();
    t_saved();
    t_saved_usr();
    t_cst();
    t_unknown();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule